// File: doc/BRIEF.md
# Eight-Bit Accumulator-Free Stack Core

A very small processor core built around a hardware operand stack. Each 8-bit word in its 32-word unified memory is either data or an instruction. An instruction carries a 3-bit opcode above a 5-bit operand. The operand is a memory address, a jump target, a compare literal, a rotate count or an add literal. The core executes one instruction per clock, straight from a combinational-read memory.

A host loads programs and data, and reads results, through a word-wide memory port. That port only writes while the core is halted with `run_i` low. While `run_i` is high the core fetches from the word at its program counter and executes it on the next rising edge. The program counter and the top of the stack are brought out for observation.

Top module: `stk8_core`

## Requirements
- R1: An instruction word holds the opcode in bits [7:5] and the operand x in bits [4:0]. Opcode 000 does nothing except advance the program counter by one.
- R2: Opcode 001 with x not zero loads the program counter with x and leaves the stack unchanged.
- R3: Opcode 001 with x equal to zero reboots the core. The program counter becomes 0, every stack entry becomes empty (top reads 0) and memory keeps its contents.
- R4: Opcode 010 compares the top of stack with x, zero-extended. When they are equal the program counter advances by one. Otherwise it advances by two and the next word is skipped. The stack is not changed.
- R5: Opcode 011 rotates all 8 stack slots down by x mod 8, so the entry at depth d moves to depth (d + x) mod 8. A rotate whose amount mod 8 is zero changes nothing. Any other rotate marks all 8 slots as occupied.
- R6: Opcode 100 pushes the memory word at address x. A push onto a full 8-entry stack discards the oldest entry.
- R7: Opcode 101 pops the top of stack into memory address x. Popping an empty stack writes 0 and leaves the stack empty.
- R8: Opcode 110 adds x and opcode 111 subtracts x from the top of stack, both modulo 256. On an empty stack the top is taken as 0 and the result becomes the single entry.
- R9: The 5-bit program counter wraps from 31 to 0, for a plain advance as well as for a skip.
- R10: After reset the program counter is 0, the top of stack reads 0, the stack is empty and every memory word is 0.
- R11: While `run_i` is low the program counter and stack hold, and a host write lands in memory. While `run_i` is high, host writes are ignored. `host_rdata_o` always shows the word at `host_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: execute one instruction per clock; low: halt and allow host writes |
| host_we_i | input | 1 | Host write enable, honoured only while halted |
| host_addr_i | input | 5 | Host memory address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Memory word at host_addr_i |
| pc_o | output | 5 | Program counter |
| tos_o | output | 8 | Top of stack, 0 when the stack is empty |

## Verification
The assertions assume that reset is applied once before any instruction executes. They also assume that `run_i` and the host inputs change only away from the rising edge. Since every opcode value is defined, they place no limit on instruction contents. The stimulus loads each program with `run_i` low, raises and lowers `run_i` on falling edges to run an exact number of instructions, and reads memory only while halted. One scenario deliberately drives host writes while running, to confirm that they are dropped.

// File: rtl/stk8_pkg.sv
package stk8_pkg;

  localparam int unsigned OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 3'b000,
    OP_JMP  = 3'b001,
    OP_SKNE = 3'b010,
    OP_ROT  = 3'b011,
    OP_PUSH = 3'b100,
    OP_POP  = 3'b101,
    OP_ADD  = 3'b110,
    OP_SUB  = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    SC_HOLD,
    SC_PUSH,
    SC_POP,
    SC_ROT,
    SC_ADD,
    SC_CLR
  } stk_cmd_e;

endpackage

// File: rtl/stk8_mem.sv
module stk8_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [DATA_W-1:0] fetch_data_o,
  input  logic [ADDR_W-1:0] data_addr_i,
  output logic [DATA_W-1:0] data_rdata_o,
  input  logic              core_we_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  input  logic              host_en_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  localparam int unsigned WORDS = 2 ** ADDR_W;

  logic [WORDS-1:0][DATA_W-1:0] words;
  logic                         host_wr;

  assign host_wr = host_en_i && host_we_i;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (core_we_i && data_addr_i == ADDR_W'(i)) begin
        word_q <= core_wdata_i;
      end else if (host_wr && host_addr_i == ADDR_W'(i)) begin
        word_q <= host_wdata_i;
      end
    end
    assign words[i] = word_q;
  end

  assign fetch_data_o = words[fetch_addr_i];
  assign data_rdata_o = words[data_addr_i];
  assign host_rdata_o = words[host_addr_i];

  // core and host never write in the same cycle
  p_write_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we_i |-> !host_en_i);

  // a host write while halted is visible next cycle
  p_host_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr && !core_we_i) |=> words[$past(host_addr_i)] == $past(host_wdata_i));

endmodule

// File: rtl/stk8_stack.sv
module stk8_stack import stk8_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ARG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_cmd_e          cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ARG_W-1:0]  arg_i,
  output logic [DATA_W-1:0] top_o
);
  // DEPTH must be a power of two: pointer arithmetic wraps naturally
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [DEPTH-1:0][DATA_W-1:0] slot_q, slot_d;
  logic [PTR_W-1:0]             tp_q, tp_d, push_ptr, rot_k;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic                         full, empty;

  assign full     = cnt_q == CNT_W'(DEPTH);
  assign empty    = cnt_q == '0;
  assign push_ptr = tp_q + 1'b1;
  assign rot_k    = PTR_W'(arg_i % ARG_W'(DEPTH));

  always_comb begin
    slot_d = slot_q;
    tp_d   = tp_q;
    cnt_d  = cnt_q;
    unique case (cmd_i)
      SC_PUSH: begin
        tp_d             = push_ptr;
        slot_d[push_ptr] = wdata_i;
        if (!full) cnt_d = cnt_q + 1'b1;
      end
      SC_POP: begin
        if (!empty) begin
          slot_d[tp_q] = '0;  // keeps vacated slots at zero
          tp_d         = tp_q - 1'b1;
          cnt_d        = cnt_q - 1'b1;
        end
      end
      SC_ROT: begin
        if (rot_k != '0) begin
          tp_d  = tp_q + rot_k;
          cnt_d = CNT_W'(DEPTH);
        end
      end
      SC_ADD: begin
        slot_d[tp_q] = slot_q[tp_q] + wdata_i;
        if (empty) cnt_d = CNT_W'(1);
      end
      SC_CLR: begin
        slot_d = '0;
        tp_d   = '0;
        cnt_d  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      tp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      tp_q   <= tp_d;
      cnt_q  <= cnt_d;
    end
  end

  assign top_o = slot_q[tp_q];

  p_empty_top_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> (top_o == '0));

  p_push_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == SC_PUSH) |=> (top_o == $past(wdata_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == SC_CLR) |=> (cnt_q == '0 && top_o == '0));

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/stk8_ctrl.sv
module stk8_ctrl import stk8_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  input  logic [DATA_W-1:0] tos_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] arg_o,
  output stk_cmd_e          stk_cmd_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  opcode_e           op;
  logic [ADDR_W-1:0] x, pc_q, pc_d;
  logic [DATA_W-1:0] x_ext;

  assign op    = opcode_e'(instr_i[DATA_W-1 -: OPC_W]);
  assign x     = instr_i[ADDR_W-1:0];
  assign x_ext = DATA_W'(x);

  always_comb begin
    pc_d       = pc_q;
    stk_cmd_o  = SC_HOLD;
    stk_data_o = '0;
    mem_we_o   = 1'b0;
    if (run_i) begin
      pc_d = pc_q + 1'b1;
      unique case (op)
        OP_JMP: begin
          if (x == '0) begin
            pc_d      = '0;
            stk_cmd_o = SC_CLR;
          end else begin
            pc_d = x;
          end
        end
        OP_SKNE: if (tos_i != x_ext) pc_d = pc_q + ADDR_W'(2);
        OP_ROT:  stk_cmd_o = SC_ROT;
        OP_PUSH: begin
          stk_cmd_o  = SC_PUSH;
          stk_data_o = dmem_rdata_i;
        end
        OP_POP: begin
          stk_cmd_o = SC_POP;
          mem_we_o  = 1'b1;
        end
        OP_ADD: begin
          stk_cmd_o  = SC_ADD;
          stk_data_o = x_ext;
        end
        OP_SUB: begin
          stk_cmd_o  = SC_ADD;
          stk_data_o = DATA_W'(0) - x_ext;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign arg_o       = x;
  assign mem_wdata_o = tos_i;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));

  p_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && op == OP_NOP) |=> pc_q == $past(pc_q) + ADDR_W'(1));

  p_jump_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && op == OP_JMP && x != '0) |=> pc_q == $past(x));

  p_reboot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && op == OP_JMP && x == '0) |=> pc_q == '0);

  p_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && op == OP_SKNE && tos_i != x_ext) |=> pc_q == $past(pc_q) + ADDR_W'(2));

  p_pop_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (run_i && stk_cmd_o == SC_POP));

endmodule

// File: rtl/stk8_core.sv
module stk8_core import stk8_pkg::*; #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STACK_DEPTH = 8,
  localparam int unsigned ADDR_W     = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] tos_o
);
  logic [DATA_W-1:0] instr, dmem_rdata, stk_data, mem_wdata, top;
  logic [ADDR_W-1:0] pc, arg;
  stk_cmd_e          stk_cmd;
  logic              mem_we;

  stk8_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_addr_i (pc),
    .fetch_data_o (instr),
    .data_addr_i  (arg),
    .data_rdata_o (dmem_rdata),
    .core_we_i    (mem_we),
    .core_wdata_i (mem_wdata),
    .host_en_i    (!run_i),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o)
  );

  stk8_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .instr_i      (instr),
    .dmem_rdata_i (dmem_rdata),
    .tos_i        (top),
    .pc_o         (pc),
    .arg_o        (arg),
    .stk_cmd_o    (stk_cmd),
    .stk_data_o   (stk_data),
    .mem_we_o     (mem_we),
    .mem_wdata_o  (mem_wdata)
  );

  stk8_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH), .ARG_W(ADDR_W)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (stk_cmd),
    .wdata_i (stk_data),
    .arg_i   (arg),
    .top_o   (top)
  );

  assign pc_o  = pc;
  assign tos_o = top;

endmodule

// File: tb/test_stk8_core.sv
module test_stk8_core;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       host_we_i = 1'b0;
  logic [4:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic [4:0] pc_o;
  logic [7:0] tos_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] NOP = 3'b000, JMP = 3'b001, SKNE = 3'b010, ROT = 3'b011,
                         PSH = 3'b100, POP = 3'b101, ADD = 3'b110, SUB = 3'b111;

  always #2.5 clk_i = ~clk_i;

  stk8_core i_stk8_core (
    .clk_i, .rst_ni, .run_i, .host_we_i, .host_addr_i, .host_wdata_i,
    .host_rdata_o, .pc_o, .tos_o
  );

  function automatic logic [7:0] enc(logic [2:0] op, logic [4:0] x);
    return {op, x};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    run_i = 1'b0; host_we_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk_i);
    host_addr_i = a[4:0]; host_wdata_i = d; host_we_i = 1'b1;
    @(posedge clk_i);
    #1 host_we_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk_i);
    host_addr_i = a[4:0];
    #0.5 v = int'(host_rdata_o);
  endtask

  task automatic step(int n);
    @(negedge clk_i);
    run_i = 1'b1;
    repeat (n) @(negedge clk_i);
    run_i = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    check("R10", "pc after reset", pc_o, 0);
    check("R10", "tos after reset", tos_o, 0);
    rd(0, v);  check("R10", "mem[0] after reset", v, 0);
    rd(31, v); check("R10", "mem[31] after reset", v, 0);
  endtask

  task automatic t_nop_wrap();
    do_reset();
    step(33);
    check("R1", "pc after 33 nops", pc_o, 1);
    check("R9", "tos after nops", tos_o, 0);
  endtask

  task automatic t_push_pop();
    int v;
    do_reset();
    wr(20, 8'h5A); wr(21, 8'h33);
    wr(0, enc(PSH, 20)); wr(1, enc(PSH, 21));
    wr(2, enc(POP, 25)); wr(3, enc(POP, 26));
    step(2);
    check("R6", "tos after two pushes", tos_o, 8'h33);
    check("R6", "pc after two pushes", pc_o, 2);
    step(2);
    rd(25, v); check("R7", "first pop target", v, 8'h33);
    rd(26, v); check("R7", "second pop target", v, 8'h5A);
    check("R7", "tos after draining", tos_o, 0);
  endtask

  task automatic t_empty_pop();
    int v;
    do_reset();
    wr(10, 8'h77);
    wr(0, enc(POP, 10)); wr(1, enc(ADD, 3));
    step(1);
    rd(10, v); check("R7", "empty pop writes zero", v, 0);
    check("R7", "tos stays zero", tos_o, 0);
    step(1);
    check("R8", "add on empty stack", tos_o, 3);
  endtask

  task automatic t_overflow();
    int v;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      wr(20 + i, 8'(i + 1));
      wr(i, enc(PSH, 5'(20 + i)));
    end
    for (int i = 9; i < 18; i++) wr(i, enc(POP, 31));
    step(9);
    check("R6", "tos after nine pushes", tos_o, 9);
    step(7);
    check("R6", "tos after seven pops", tos_o, 2);
    step(1);
    check("R6", "oldest discarded, stack empty", tos_o, 0);
    rd(31, v); check("R6", "eighth pop value", v, 2);
    step(1);
    rd(31, v); check("R7", "ninth pop on empty", v, 0);
    check("R1", "pc after eighteen", pc_o, 18);
  endtask

  task automatic t_arith();
    do_reset();
    wr(0, enc(SUB, 1)); wr(1, enc(ADD, 2));
    wr(2, enc(ADD, 31)); wr(3, enc(SUB, 31));
    step(1); check("R8", "0 - 1 wraps", tos_o, 8'hFF);
    step(1); check("R8", "0xFF + 2 wraps", tos_o, 8'h01);
    step(1); check("R8", "add 31", tos_o, 8'h20);
    step(1); check("R8", "subtract 31", tos_o, 8'h01);
  endtask

  task automatic t_skip();
    do_reset();
    wr(0, enc(ADD, 7));  wr(1, enc(SKNE, 7)); wr(2, enc(ADD, 1));
    wr(3, enc(SKNE, 7)); wr(4, enc(ADD, 16)); wr(5, enc(ADD, 2));
    step(2);
    check("R4", "equal compare advances by one", pc_o, 2);
    check("R4", "compare leaves tos", tos_o, 7);
    step(2);
    check("R4", "unequal compare skips", pc_o, 5);
    check("R4", "tos before skipped word", tos_o, 8);
    step(1);
    check("R4", "skipped word not executed", tos_o, 10);
  endtask

  task automatic t_jump();
    do_reset();
    wr(0, enc(ADD, 4)); wr(1, enc(JMP, 12)); wr(12, enc(ADD, 1));
    wr(13, enc(JMP, 31)); wr(31, enc(SKNE, 6));
    step(2);
    check("R2", "jump target", pc_o, 12);
    check("R2", "jump keeps tos", tos_o, 4);
    step(1);
    check("R2", "executes at target", tos_o, 5);
    step(2);
    check("R9", "skip from 31 wraps to 1", pc_o, 1);
  endtask

  task automatic t_reboot();
    int v;
    do_reset();
    wr(30, 8'h99); wr(28, 8'h11); wr(29, 8'h11);
    wr(0, enc(PSH, 30)); wr(1, enc(PSH, 30)); wr(2, enc(JMP, 0));
    step(3);
    check("R3", "pc after reboot", pc_o, 0);
    check("R3", "tos after reboot", tos_o, 0);
    rd(30, v); check("R3", "memory kept", v, 8'h99);
    wr(0, enc(POP, 29)); wr(1, enc(POP, 28));
    check("R11", "pc held during host writes", pc_o, 0);
    step(2);
    rd(29, v); check("R3", "stack emptied (first pop)", v, 0);
    rd(28, v); check("R3", "stack emptied (second pop)", v, 0);
  endtask

  task automatic t_rotate();
    int v;
    do_reset();
    wr(24, 8'h10); wr(25, 8'h20); wr(26, 8'h30);
    wr(0, enc(PSH, 24)); wr(1, enc(PSH, 25)); wr(2, enc(PSH, 26));
    wr(3, enc(ROT, 0));  wr(4, enc(ROT, 8));  wr(5, enc(ROT, 2));
    wr(6, enc(ROT, 6));  wr(7, enc(ROT, 7));  wr(8, enc(POP, 31));
    step(4); check("R5", "rotate 0 no change", tos_o, 8'h30);
    step(1); check("R5", "rotate 8 no change", tos_o, 8'h30);
    step(1); check("R5", "rotate 2 brings depth 6", tos_o, 0);
    step(1); check("R5", "rotate 6 completes cycle", tos_o, 8'h30);
    step(1); check("R5", "rotate 7 brings depth 1", tos_o, 8'h20);
    step(1);
    rd(31, v); check("R5", "pop after rotate", v, 8'h20);
    check("R5", "new top after pop", tos_o, 8'h10);
  endtask

  task automatic t_host_ignore();
    int v;
    do_reset();
    @(negedge clk_i);
    host_addr_i = 5'd15; host_wdata_i = 8'hAB; host_we_i = 1'b1; run_i = 1'b1;
    repeat (4) @(negedge clk_i);
    run_i = 1'b0; host_we_i = 1'b0;
    check("R11", "core ran while host wrote", pc_o, 4);
    rd(15, v); check("R11", "host write ignored while running", v, 0);
    repeat (5) @(negedge clk_i);
    check("R11", "pc held while halted", pc_o, 4);
  endtask

  initial begin
    t_reset();
    t_nop_wrap();
    t_push_pop();
    t_empty_pop();
    t_overflow();
    t_arith();
    t_skip();
    t_jump();
    t_reboot();
    t_rotate();
    t_host_ignore();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule